// File: doc/BRIEF.md
# Flash Erase Region Resolver

This block sits between a flash command decoder and the erase engine. For each erase request it takes the erase-size class, a byte address and two sector-map configuration bits. It decides whether the erase is legal for the current layout. For a legal erase it reports the aligned region to clear, as a start address and a byte length.

Two layouts are supported. In the mixed layout, sixteen 4 KB parameter sectors form one 64 KB zone at the bottom or the top of the array, and the rest of the array is made of 64 KB uniform sectors. In the uniform layout the array is made only of 256 KB sectors, with no parameter zone. The array size is set by the address width. The top parameter zone is therefore derived from the highest address.

A result appears one clock after the request, with either an accept flag or a reject flag.

Top module: `erase_region_resolver`

## Requirements
- R1: `res_valid` is high in the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low.
- R2: While `res_valid` is high, exactly one of `res_ok` and `res_reject` is high. While `res_valid` is low, both are low.
- R3: `req_kind` is encoded as follows: 0 = 4 KB, 1 = 8 KB, 2 = 64 KB, 3 = 256 KB. An 8 KB request is always rejected.
- R4: A 4 KB erase is accepted only when `cfg_uniform` is 0 and the address lies in the parameter zone. With `cfg_param_top` = 0 the zone is the lowest 64 KB of the array. With `cfg_param_top` = 1 it is the highest 64 KB, ending at 2^ADDR_W − 1.
- R5: A 64 KB erase is accepted at any address when `cfg_uniform` is 0. Over the parameter zone it covers all sixteen 4 KB sectors.
- R6: A 256 KB erase is accepted only when `cfg_uniform` is 1, and a 64 KB erase is rejected when `cfg_uniform` is 1.
- R7: A 4 KB erase is rejected when `cfg_uniform` is 1, even at an address that would lie in the zone.
- R8: For an accepted erase, `res_start` is the request address rounded down to a multiple of the erase size. `res_len` is the size in bytes (4096, 65536 or 262144).
- R9: For a rejected erase, `res_len` is 0 and `res_start` is 0.
- R10: During and directly after reset, `res_valid`, `res_ok` and `res_reject` are 0, and `res_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request present this cycle |
| req_kind | input | 2 | Erase size class (0=4K, 1=8K, 2=64K, 3=256K) |
| req_addr | input | ADDR_W | Byte address of the request |
| cfg_uniform | input | 1 | 1 = all 256 KB uniform layout; 0 = parameter zone plus 64 KB sectors |
| cfg_param_top | input | 1 | 1 = parameter zone at top of array; 0 = at bottom |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_ok | output | 1 | Erase accepted |
| res_reject | output | 1 | Erase rejected |
| res_start | output | ADDR_W | Aligned start address of the region (0 on reject) |
| res_len | output | 19 | Region length in bytes (0 on reject) |

## Verification
The 4 KB class is driven at the first and last byte of the parameter zone and one byte past each edge, in both zone placements. This separates a correct zone compare from an off-by-one compare or a swapped top/bottom test. The 64 KB and 256 KB classes are driven with unaligned addresses under both layouts. This shows whether the alignment mask and the layout gating are tied to the right size. The 8 KB class is tried under every configuration to show it never leaks through. Back-to-back requests with mixed outcomes check that each result stays paired with its own request.

// File: rtl/ers_pkg.sv
package ers_pkg;

    typedef enum logic [1:0] {
        ERS_4K   = 2'd0,
        ERS_8K   = 2'd1,
        ERS_64K  = 2'd2,
        ERS_256K = 2'd3
    } ers_kind_e;

    localparam int PSECT_LG  = 12;
    localparam int PSECT_NUM = 16;
    localparam int ZONE_LG   = PSECT_LG + $clog2(PSECT_NUM);
    localparam int BIG_LG    = 18;
    localparam int LEN_W     = BIG_LG + 1;
    localparam int LG_W      = 5;

    typedef struct packed {
        logic            ok;
        logic [LG_W-1:0] lg;
    } ers_verdict_t;

    function automatic logic [LG_W-1:0] kind_lg(ers_kind_e k);
        case (k)
            ERS_4K:  return LG_W'(PSECT_LG);
            ERS_8K:  return LG_W'(PSECT_LG + 1);
            ERS_64K: return LG_W'(ZONE_LG);
            default: return LG_W'(BIG_LG);
        endcase
    endfunction

endpackage

// File: rtl/ers_zone_detect.sv
module ers_zone_detect #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-ers_pkg::ZONE_LG-1:0] addr_hi,
    input  logic                               param_top,
    output logic                               in_zone
);
    // The zone is one ZONE_LG-sized block: block index 0 or the highest index.
    always_comb begin
        if (param_top) in_zone = &addr_hi;
        else           in_zone = ~|addr_hi;
    end
endmodule

// File: rtl/ers_rule_check.sv
module ers_rule_check
    import ers_pkg::*;
(
    input  ers_kind_e    kind,
    input  logic         uniform,
    input  logic         in_zone,
    output ers_verdict_t verdict
);
    always_comb begin
        verdict.lg = kind_lg(kind);
        case (kind)
            ERS_4K:   verdict.ok = !uniform && in_zone;
            ERS_8K:   verdict.ok = 1'b0;
            ERS_64K:  verdict.ok = !uniform;
            ERS_256K: verdict.ok = uniform;
            default:  verdict.ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ers_align.sv
module ers_align #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 19,
    parameter int LG_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LG_W-1:0]   lg,
    input  logic              ok,
    output logic [ADDR_W-1:0] start,
    output logic [LEN_W-1:0]  len
);
    logic [ADDR_W-1:0] mask;

    always_comb begin
        mask  = {ADDR_W{1'b1}} << lg;
        start = ok ? (addr & mask) : '0;
        len   = ok ? (LEN_W'(1) << lg) : '0;
    end
endmodule

// File: rtl/erase_region_resolver.sv
module erase_region_resolver
    import ers_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 cfg_uniform,
    input  logic                 cfg_param_top,
    output logic                 res_valid,
    output logic                 res_ok,
    output logic                 res_reject,
    output logic [ADDR_W-1:0]    res_start,
    output logic [LEN_W-1:0]     res_len
);
    localparam int HI_W = ADDR_W - ZONE_LG;

    ers_kind_e         kind;
    logic              in_zone;
    ers_verdict_t      verdict;
    logic [ADDR_W-1:0] nxt_start;
    logic [LEN_W-1:0]  nxt_len;

    assign kind = ers_kind_e'(req_kind);

    ers_zone_detect #(.ADDR_W(ADDR_W)) u_zone (
        .addr_hi   (req_addr[ADDR_W-1:ZONE_LG]),
        .param_top (cfg_param_top),
        .in_zone   (in_zone)
    );

    ers_rule_check u_rule (
        .kind    (kind),
        .uniform (cfg_uniform),
        .in_zone (in_zone),
        .verdict (verdict)
    );

    ers_align #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LG_W(LG_W)) u_align (
        .addr  (req_addr),
        .lg    (verdict.lg),
        .ok    (verdict.ok),
        .start (nxt_start),
        .len   (nxt_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_ok     <= 1'b0;
            res_reject <= 1'b0;
            res_start  <= '0;
            res_len    <= '0;
        end else begin
            res_valid  <= req_valid;
            res_ok     <= req_valid && verdict.ok;
            res_reject <= req_valid && !verdict.ok;
            res_start  <= req_valid ? nxt_start : '0;
            res_len    <= req_valid ? nxt_len : '0;
        end
    end

    if (HI_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed the parameter zone width");
    end
endmodule

// File: rtl/ers_chk.sv
module ers_chk #(
    parameter int ADDR_W = 24
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic [1:0]                  req_kind,
    input logic                        cfg_uniform,
    input logic                        res_valid,
    input logic                        res_ok,
    input logic                        res_reject,
    input logic [ADDR_W-1:0]           res_start,
    input logic [ers_pkg::LEN_W-1:0]   res_len
);
    // R1
    req_to_res_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    // R2
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_ok ^ res_reject));
    // R2
    no_stray_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !(res_ok || res_reject));
    // R3
    two_sector_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1) |=> res_reject);
    // R6
    mid_in_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && cfg_uniform) |=> res_reject);
    // R8
    len_power_chk: assert property (@(posedge clk) disable iff (rst)
        res_ok |-> ($countones(res_len) == 1 && res_start[11:0] == 12'd0));
    // R9
    reject_zero_chk: assert property (@(posedge clk) disable iff (rst)
        res_reject |-> (res_len == '0 && res_start == '0));
endmodule

bind erase_region_resolver ers_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .cfg_uniform (cfg_uniform),
    .res_valid   (res_valid),
    .res_ok      (res_ok),
    .res_reject  (res_reject),
    .res_start   (res_start),
    .res_len     (res_len)
);

// File: tb/erase_region_resolver_bench.sv
module erase_region_resolver_bench;
    localparam int AW = 24;
    localparam int LW = 19;

    typedef struct {
        logic          ok;
        logic [AW-1:0] start;
        logic [LW-1:0] len;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic          cfg_uniform = 1'b0;
    logic          cfg_param_top = 1'b0;
    logic          res_valid, res_ok, res_reject;
    logic [AW-1:0] res_start;
    logic [LW-1:0] res_len;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    erase_region_resolver #(.ADDR_W(AW)) u_erase_region_resolver (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .cfg_uniform(cfg_uniform), .cfg_param_top(cfg_param_top),
        .res_valid(res_valid), .res_ok(res_ok), .res_reject(res_reject),
        .res_start(res_start), .res_len(res_len)
    );

    function automatic exp_t model(logic [1:0] k, logic [AW-1:0] a, logic uni, logic top, string tag);
        exp_t e;
        int   lg;
        logic zone;
        zone = top ? (a >= AW'((1 << AW) - 65536)) : (a < AW'(65536));
        case (k)
            2'd0: begin e.ok = !uni && zone; lg = 12; end
            2'd1: begin e.ok = 1'b0;        lg = 13; end
            2'd2: begin e.ok = !uni;        lg = 16; end
            default: begin e.ok = uni;      lg = 18; end
        endcase
        e.start = e.ok ? AW'((a / (1 << lg)) * (1 << lg)) : '0;
        e.len   = e.ok ? LW'(1 << lg) : '0;
        e.tag   = tag;
        return e;
    endfunction

    task automatic send(logic [1:0] k, logic [AW-1:0] a, logic uni, logic top, string tag);
        @(negedge clk);
        req_valid     = 1'b1;
        req_kind      = k;
        req_addr      = a;
        cfg_uniform   = uni;
        cfg_param_top = top;
        sb.push_back(model(k, a, uni, top, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: results appear one posedge after the request; sampled on negedge.
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1: result with no pending request (valid=%0b expected 0)", res_valid);
            end else begin
                e = sb.pop_front();
                if (res_ok !== e.ok || res_reject !== !e.ok ||
                    res_start !== e.start || res_len !== e.len) begin
                    errors++;
                    $display("FAIL %s: ok=%0b rej=%0b start=%h len=%0d expected ok=%0b rej=%0b start=%h len=%0d",
                             e.tag, res_ok, res_reject, res_start, res_len,
                             e.ok, !e.ok, e.start, e.len);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_ok !== 1'b0 || res_reject !== 1'b0 || res_len !== '0) begin
            errors++;
            $display("FAIL R10: valid=%0b ok=%0b rej=%0b len=%0d expected all 0",
                     res_valid, res_ok, res_reject, res_len);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_ok !== 1'b0 || res_reject !== 1'b0) begin
            errors++;
            $display("FAIL R10: after reset valid=%0b ok=%0b rej=%0b expected 0",
                     res_valid, res_ok, res_reject);
        end

        // Bottom zone, mixed layout
        send(2'd0, 24'h003456, 1'b0, 1'b0, "R4 bottom inside");
        send(2'd0, 24'h00FFFF, 1'b0, 1'b0, "R4 bottom last byte");
        send(2'd0, 24'h010000, 1'b0, 1'b0, "R4 bottom just past");
        send(2'd2, 24'h005123, 1'b0, 1'b0, "R5 group over zone");
        send(2'd2, 24'h123456, 1'b0, 1'b0, "R8 64K align");
        send(2'd3, 24'h123456, 1'b0, 1'b0, "R6 256K in mixed");
        send(2'd1, 24'h002000, 1'b0, 1'b0, "R3 8K mixed");
        idle();
        // Top zone, mixed layout
        send(2'd0, 24'hFF0000, 1'b0, 1'b1, "R4 top first byte");
        send(2'd0, 24'hFFFFFF, 1'b0, 1'b1, "R4 top last byte");
        send(2'd0, 24'hFEFFFF, 1'b0, 1'b1, "R4 top just below");
        send(2'd0, 24'h001000, 1'b0, 1'b1, "R4 bottom when top");
        send(2'd2, 24'hFF8765, 1'b0, 1'b1, "R5 top group");
        idle();
        idle();
        // Uniform layout
        send(2'd3, 24'h123456, 1'b1, 1'b0, "R6 256K uniform");
        send(2'd3, 24'hFFFFFF, 1'b1, 1'b1, "R8 256K last");
        send(2'd2, 24'h040000, 1'b1, 1'b0, "R6 64K in uniform");
        send(2'd0, 24'h001000, 1'b1, 1'b0, "R7 4K uniform bottom");
        send(2'd0, 24'hFFF000, 1'b1, 1'b1, "R7 4K uniform top");
        send(2'd1, 24'h000000, 1'b1, 1'b0, "R3 8K uniform");
        send(2'd1, 24'hFFE000, 1'b0, 1'b1, "R9 8K top zone");
        idle();
        repeat (3) @(negedge clk);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1: pending=%0d expected 0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule